// File: doc/BRIEF.md
# Lockable Four-Way Cache Replacement Selector

This block decides which of four ways of a set-associative cache takes a new line when a miss occurs. It keeps a least-recently-used ordering for every set, refreshed by hits and by its own fills. A small control register lets the two upper ways (way 2 and way 3) be held against replacement. For each of them it also has a load bit. During a prefetch miss in DSP mode, with the cache-lock status asserted, a matching lock-and-load pair sends the line to that way regardless of age.

The surrounding cache controller raises `miss_req` for one cycle with the set index and the qualifying flags. One clock later the block presents the chosen way with a one-cycle valid pulse. That choice is already recorded as most recently used. Hits are reported on a separate strobe with set and way. A small state machine has two states. `ST_IDLE` means no result is pending. `ST_EMIT` means a victim is being presented. The transitions are:

- IDLE_TO_EMIT: taken on a miss.
- EMIT_TO_EMIT: taken on a back-to-back miss.
- EMIT_TO_IDLE: taken when no miss follows.

Top module: `lockable_way_selector`

## Requirements
- R1: After reset, `victim_valid` is 0, `cfg_rdata` is 0, `cfg_err` is 0, and the ordering of every set runs from way 0 (oldest) up to way 3 (newest), so the first victim of any set is way 0.
- R2: A write with `cfg_we` stores bit 0 (way-2 lock), bit 1 (way-2 load), bit 8 (way-3 lock) and bit 9 (way-3 load). `cfg_rdata` shows these four bits in the same positions, and every other bit reads 0.
- R3: A cycle with `miss_req` high gives `victim_valid` high in the next cycle, with `victim_way` valid in that same cycle. `victim_valid` is never high unless `miss_req` was high in the cycle before, so a single miss yields a pulse of exactly one cycle.
- R4: With no lock bit active, the victim is the least recently used way of the set. A hit (`hit_req` with `hit_set`, `hit_way`) makes that way the most recently used of its set from the next cycle on, and leaves other sets unchanged.
- R5: The way returned for a miss becomes the most recently used way of that set, so repeated misses to one set with nothing locked cycle through the ways in age order.
- R6: With `dsp_mode` high and no forced load, a way whose lock bit is set is never chosen. The victim is the oldest among way 0, way 1 and the unlocked upper ways.
- R7: With `dsp_mode` low, the lock bits are ignored for victim choice and all four ways compete on age.
- R8: When `miss_pref`, `dsp_mode`, `lock_en`, the way-2 lock and the way-2 load are all 1, the victim is way 2, even when it is the newest way.
- R9: When `miss_pref`, `dsp_mode`, `lock_en`, the way-3 lock and the way-3 load are all 1, and the way-2 forcing condition does not hold, the victim is way 3.
- R10: `cfg_err` is 1 exactly while both load bits are stored as 1. If both forcing conditions hold at once, way 2 wins.
- R11: A miss that lacks any one of the forcing inputs (prefetch, DSP mode or lock status) falls back to age-based choice under R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents, unused bits zero |
| cfg_err | output | 1 | Both load bits set (illegal setting) |
| miss_req | input | 1 | Miss strobe, one cycle per miss |
| miss_set | input | 6 | Set index of the miss |
| miss_pref | input | 1 | Miss was caused by a prefetch |
| dsp_mode | input | 1 | DSP mode is active |
| lock_en | input | 1 | Cache-lock status flag |
| hit_req | input | 1 | Hit report strobe |
| hit_set | input | 6 | Set index of the hit |
| hit_way | input | 2 | Way that hit |
| victim_valid | output | 1 | Victim result valid, one cycle after a miss |
| victim_way | output | 2 | Way chosen for the fill |

## Verification
On every cycle, the assertions watch the miss-to-valid pairing and the forced choice of way 2 or way 3. They also check that a locked way is never picked in DSP mode when it is not being loaded, and that the age comparison always names exactly one oldest candidate. Some behaviours show only across a sequence of events, and the directed scenarios cover them. These are the hit and fill age ordering, isolation between sets, the rotation of repeated fills, the readback layout of the register, and the fallback to age order when one forcing input is missing.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int NUM_WAYS = 4;
    localparam int ORD_W    = 6;

    typedef logic [1:0]       way_t;
    typedef logic [ORD_W-1:0] ord_t;

    typedef struct packed {
        logic ld3;
        logic lk3;
        logic ld2;
        logic lk2;
    } lock_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } sel_state_e;

    // bit index of the pair (i, j), i < j
    function automatic int pair_idx(input int i, input int j);
        if (i == 0)      return j - 1;
        else if (i == 1) return j + 1;
        else             return 5;
    endfunction

    // bit set: lower way of the pair used more recently than the upper one
    function automatic logic is_older(input ord_t o, input int k, input int m);
        if (k < m) return !o[pair_idx(k, m)];
        else       return  o[pair_idx(m, k)];
    endfunction

    function automatic ord_t make_newest(input ord_t o, input way_t w);
        ord_t r;
        r = o;
        for (int i = 0; i < NUM_WAYS; i++) begin
            for (int j = i + 1; j < NUM_WAYS; j++) begin
                if (int'(w) == i) r[pair_idx(i, j)] = 1'b1;
                if (int'(w) == j) r[pair_idx(i, j)] = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lws_cfg_reg.sv
module lws_cfg_reg
    import lws_pkg::*;
#(
    parameter int DW      = 32,
    parameter int LK2_POS = 0,
    parameter int LD2_POS = 1,
    parameter int LK3_POS = 8,
    parameter int LD3_POS = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output lock_cfg_t     cfg,
    output logic          err
);

    lock_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.lk2 <= wdata[LK2_POS];
            cfg_q.ld2 <= wdata[LD2_POS];
            cfg_q.lk3 <= wdata[LK3_POS];
            cfg_q.ld3 <= wdata[LD3_POS];
        end
    end

    always_comb begin
        rdata          = '0;
        rdata[LK2_POS] = cfg_q.lk2;
        rdata[LD2_POS] = cfg_q.ld2;
        rdata[LK3_POS] = cfg_q.lk3;
        rdata[LD3_POS] = cfg_q.ld3;
    end

    assign cfg = cfg_q;
    assign err = cfg_q.ld2 & cfg_q.ld3;

endmodule

// File: rtl/lws_lru_store.sv
module lws_lru_store
    import lws_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output ord_t             rd_ord,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  way_t             wr_way
);

    ord_t ord_mem [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ord_mem[s] <= '0;
        end else if (wr_en) begin
            ord_mem[wr_set] <= make_newest(ord_mem[wr_set], wr_way);
        end
    end

    assign rd_ord = ord_mem[rd_set];

endmodule

// File: rtl/lws_victim_pick.sv
module lws_victim_pick
    import lws_pkg::*;
(
    input  ord_t      ord,
    input  lock_cfg_t cfg,
    input  logic      pref,
    input  logic      dsp,
    input  logic      lock_st,
    output way_t      way,
    output logic [NUM_WAYS-1:0] oldest
);

    logic force2;
    logic force3;
    logic [NUM_WAYS-1:0] cand;

    assign force2 = pref & dsp & lock_st & cfg.lk2 & cfg.ld2;
    assign force3 = pref & dsp & lock_st & cfg.lk3 & cfg.ld3;
    assign cand   = dsp ? {~cfg.lk3, ~cfg.lk2, 2'b11} : {NUM_WAYS{1'b1}};

    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_age
        always_comb begin
            oldest[k] = cand[k];
            for (int m = 0; m < NUM_WAYS; m++) begin
                if (m != k && cand[m] && !is_older(ord, k, m)) oldest[k] = 1'b0;
            end
        end
    end

    always_comb begin
        way = '0;
        if (force2) begin
            way = 2'd2;
        end else if (force3) begin
            way = 2'd3;
        end else begin
            for (int k = NUM_WAYS - 1; k >= 0; k--) begin
                if (oldest[k]) way = way_t'(k);
            end
        end
    end

endmodule

// File: rtl/lockable_way_selector.sv
module lockable_way_selector
    import lws_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int SET_W = $clog2(SETS),
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic             cfg_err,
    input  logic             miss_req,
    input  logic [SET_W-1:0] miss_set,
    input  logic             miss_pref,
    input  logic             dsp_mode,
    input  logic             lock_en,
    input  logic             hit_req,
    input  logic [SET_W-1:0] hit_set,
    input  logic [1:0]       hit_way,
    output logic             victim_valid,
    output logic [1:0]       victim_way
);

    sel_state_e state_q, state_d;
    lock_cfg_t  cfg;
    ord_t       cur_ord;
    way_t       pick_way;
    way_t       way_q;
    logic [NUM_WAYS-1:0] oldest_vec;
    logic             upd_en;
    logic [SET_W-1:0] upd_set;
    way_t             upd_way;

    lws_cfg_reg #(.DW(DW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    lws_lru_store #(.SETS(SETS), .SET_W(SET_W)) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (miss_set),
        .rd_ord (cur_ord),
        .wr_en  (upd_en),
        .wr_set (upd_set),
        .wr_way (upd_way)
    );

    lws_victim_pick u_pick (
        .ord     (cur_ord),
        .cfg     (cfg),
        .pref    (miss_pref),
        .dsp     (dsp_mode),
        .lock_st (lock_en),
        .way     (pick_way),
        .oldest  (oldest_vec)
    );

    // a fill takes the single update port ahead of a coincident hit
    always_comb begin
        upd_en  = miss_req | hit_req;
        upd_set = miss_req ? miss_set : hit_set;
        upd_way = miss_req ? pick_way : way_t'(hit_way);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (miss_req)  state_d = ST_EMIT;
            ST_EMIT: if (!miss_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        way_q <= '0;
        else if (miss_req) way_q <= pick_way;
    end

    always_comb begin
        victim_valid = 1'b0;
        victim_way   = way_q;
        unique case (state_q)
            ST_IDLE: victim_valid = 1'b0;
            ST_EMIT: victim_valid = 1'b1;
            default: victim_valid = 1'b0;
        endcase
    end

    // R3
    miss_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |=> victim_valid);

    // R3
    valid_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(miss_req));

    // R8
    force_way2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && miss_pref && dsp_mode && lock_en && cfg_rdata[0] && cfg_rdata[1])
        |=> (victim_way == 2'd2));

    // R9
    force_way3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && miss_pref && dsp_mode && lock_en && cfg_rdata[8] && cfg_rdata[9]
         && !(cfg_rdata[0] && cfg_rdata[1]))
        |=> (victim_way == 2'd3));

    // R6
    lock2_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && dsp_mode && cfg_rdata[0] && !cfg_rdata[1])
        |=> (victim_way != 2'd2));

    // R6
    lock3_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && dsp_mode && cfg_rdata[8] && !cfg_rdata[9])
        |=> (victim_way != 2'd3));

    // R4
    single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> $onehot(oldest_vec));

endmodule

// File: tb/sim_lockable_way_selector.sv
`timescale 1ns/1ps
module sim_lockable_way_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        miss_req = 1'b0;
    logic [5:0]  miss_set = '0;
    logic        miss_pref = 1'b0;
    logic        dsp_mode = 1'b0;
    logic        lock_en = 1'b0;
    logic        hit_req = 1'b0;
    logic [5:0]  hit_set = '0;
    logic [1:0]  hit_way = '0;
    logic        victim_valid;
    logic [1:0]  victim_way;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lockable_way_selector u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .cfg_err      (cfg_err),
        .miss_req     (miss_req),
        .miss_set     (miss_set),
        .miss_pref    (miss_pref),
        .dsp_mode     (dsp_mode),
        .lock_en      (lock_en),
        .hit_req      (hit_req),
        .hit_set      (hit_set),
        .hit_way      (hit_way),
        .victim_valid (victim_valid),
        .victim_way   (victim_way)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_hit(input logic [5:0] s, input logic [1:0] w);
        @(negedge clk);
        hit_req = 1'b1;
        hit_set = s;
        hit_way = w;
        @(negedge clk);
        hit_req = 1'b0;
    endtask

    task automatic do_miss(input logic [5:0] s, input logic pf, input logic dsp,
                           input logic cl, input logic [1:0] exp, input string tag);
        @(negedge clk);
        miss_req  = 1'b1;
        miss_set  = s;
        miss_pref = pf;
        dsp_mode  = dsp;
        lock_en   = cl;
        @(negedge clk);
        miss_req = 1'b0;
        check({tag, " valid"}, {31'b0, victim_valid}, 32'd1);
        check({tag, " way"}, {30'b0, victim_way}, {30'b0, exp});
    endtask

    task automatic t_reset;
        check("R1 valid after reset", {31'b0, victim_valid}, 32'd0);
        check("R1 cfg_rdata after reset", cfg_rdata, 32'd0);
        check("R1 cfg_err after reset", {31'b0, cfg_err}, 32'd0);
        do_miss(6'd5, 0, 0, 0, 2'd0, "R1 first victim");
        @(negedge clk);
        check("R3 single pulse", {31'b0, victim_valid}, 32'd0);
    endtask

    task automatic t_rotate;
        do_miss(6'd5, 0, 0, 0, 2'd1, "R5 rotate 1");
        do_miss(6'd5, 0, 0, 0, 2'd2, "R5 rotate 2");
        do_miss(6'd5, 0, 0, 0, 2'd3, "R5 rotate 3");
        do_miss(6'd5, 0, 0, 0, 2'd0, "R5 rotate wrap");
    endtask

    task automatic t_hits;
        do_hit(6'd7, 2'd0);
        do_hit(6'd7, 2'd1);
        do_hit(6'd8, 2'd2);
        do_miss(6'd7, 0, 0, 0, 2'd2, "R4 hits age");
        do_hit(6'd7, 2'd3);
        do_miss(6'd7, 0, 0, 0, 2'd0, "R4 hit after fill");
        do_miss(6'd8, 0, 0, 0, 2'd0, "R4 other set");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        miss_req = 1'b1; miss_set = 6'd20; miss_pref = 0; dsp_mode = 0; lock_en = 0;
        @(negedge clk);
        check("R3 b2b first valid", {31'b0, victim_valid}, 32'd1);
        check("R3 b2b first way", {30'b0, victim_way}, 32'd0);
        @(negedge clk);
        miss_req = 1'b0;
        check("R3 b2b second valid", {31'b0, victim_valid}, 32'd1);
        check("R3 b2b second way", {30'b0, victim_way}, 32'd1);
        @(negedge clk);
        check("R3 b2b end", {31'b0, victim_valid}, 32'd0);
    endtask

    task automatic t_cfg;
        write_cfg(32'hFFFF_FFFF);
        check("R2 readback all ones", cfg_rdata, 32'h0000_0303);
        check("R10 err both loads", {31'b0, cfg_err}, 32'd1);
        write_cfg(32'h0000_0101);
        check("R2 readback locks", cfg_rdata, 32'h0000_0101);
        check("R10 err clear", {31'b0, cfg_err}, 32'd0);
    endtask

    task automatic t_locks;
        do_hit(6'd10, 2'd0);
        do_hit(6'd10, 2'd1);
        do_miss(6'd10, 0, 1, 1, 2'd0, "R6 locked excluded");
        do_miss(6'd10, 0, 1, 1, 2'd1, "R6 locked excluded 2");
        do_miss(6'd10, 0, 0, 1, 2'd2, "R7 dsp off ignores locks");
    endtask

    task automatic t_force;
        write_cfg(32'h0000_0003);
        do_miss(6'd11, 1, 1, 1, 2'd2, "R8 forced way2");
        do_miss(6'd11, 1, 1, 1, 2'd2, "R8 forced way2 again");
        do_miss(6'd11, 1, 1, 0, 2'd0, "R11 no lock status");
        do_miss(6'd11, 0, 1, 1, 2'd1, "R11 no prefetch");
        write_cfg(32'h0000_0300);
        do_miss(6'd12, 1, 1, 1, 2'd3, "R9 forced way3");
        do_miss(6'd12, 1, 0, 1, 2'd0, "R11 no dsp");
        write_cfg(32'h0000_0303);
        check("R10 err flagged", {31'b0, cfg_err}, 32'd1);
        do_miss(6'd13, 1, 1, 1, 2'd2, "R10 way2 priority");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rotate;
        t_hits;
        t_back_to_back;
        t_cfg;
        t_locks;
        t_force;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule